// File: doc/BRIEF.md
# Interleaved Three-Phase Variable-Frequency PWM Generator

This block drives the primary-side gates of a three-phase interleaved resonant converter. One up-counting time base sets the switching period, and three compare channels turn that count into three 50% duty square waves spaced a third of a cycle apart. Phase A is set when the count is zero and cleared at its own compare point. Phases B and C each flip on both of their two compare points, so their output is high for exactly half the cycle.

The control loop changes the period on almost every cycle. It writes a new period and five compare values into shadow slots through one write port, then pulses an arm strobe. The whole set moves into the active registers together, on the next counter wrap after the arm. A loop that spreads its writes across two switching periods therefore never runs with a period and compare set that do not belong together. The cost is up to one period of extra delay.

Top module: `ilv3_pwm`

## Requirements
- R1: `count` rises by one per clock from 0 to the active period and then returns to 0. `zero_evt` is high for exactly the one clock in which `count` is 0 after a wrap.
- R2: `phase_a` goes high on the clock after `count` is 0 and goes low on the clock after `count` equals the active slot-1 value.
- R3: `phase_b` inverts on the clock after `count` equals active slot 2 or active slot 3. `phase_c` does the same for slots 4 and 5. Reset leaves `phase_b` low and `phase_c` high.
- R4: Shadow writes with no arm leave every active value unchanged, so the cycle length seen on `count` stays the same.
- R5: After an arm, all six active slots take their shadow values at the same wrap, and that load uses up the arm.
- R6: A valid shadow write that comes after an arm cancels that arm. An arm in the same clock as a write wins.
- R7: A period written in one switching period and compares written in the next, followed by one arm, all become active together at the next wrap after the arm.
- R8: Reset gives `count`=0, `zero_evt`=0, `phase_a`=0, `phase_b`=0 and `phase_c`=1. The active period is RST_PER and the other slots hold their fractions of the RST_PER+1 cycle.
- R9: The slot map on `wr_addr` is: 0 period, 1 phase A clear, 2 and 3 phase B, 4 and 5 phase C. Writes to addresses 6 and 7 are ignored and do not cancel an arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow slot write enable |
| wr_addr | input | 3 | Shadow slot select |
| wr_data | input | CW | Shadow slot value |
| arm_load | input | 1 | One-shot arm for the next wrap |
| phase_a | output | 1 | Phase A gate signal |
| phase_b | output | 1 | Phase B gate signal |
| phase_c | output | 1 | Phase C gate signal |
| zero_evt | output | 1 | Wrap pulse |
| count | output | CW | Time-base count |

## Verification
A wrong active period shows on `count` at its very next wrap, because the peak count then differs. A wrong compare slot moves a phase edge within one cycle. An arm that is lost or left standing shows up as a cycle length on `count` that changes one period too late or too early. A phase flop with the wrong polarity stays inverted against the bench model, so it differs from the first edge on.

// File: rtl/ilv3_pkg.sv
package ilv3_pkg;
  localparam int NSLOT      = 6;
  localparam int ADDR_W     = 3;
  localparam int SLOT_PER   = 0;
  localparam int SLOT_A_CLR = 1;
  localparam int SLOT_B_X   = 2;
  localparam int SLOT_B_Y   = 3;
  localparam int SLOT_C_X   = 4;
  localparam int SLOT_C_Y   = 5;
  localparam int NPHASE     = 3;

  // point num/den of the way through a cycle of per+1 clocks
  function automatic int unsigned cycle_frac(int unsigned per, int unsigned num,
                                             int unsigned den);
    return ((per + 1) * num) / den;
  endfunction

  function automatic int unsigned reset_slot(int unsigned per, int slot);
    case (slot)
      SLOT_PER:   return per;
      SLOT_A_CLR: return cycle_frac(per, 1, 2);
      SLOT_B_X:   return cycle_frac(per, 1, 3);
      SLOT_B_Y:   return cycle_frac(per, 5, 6);
      SLOT_C_X:   return cycle_frac(per, 2, 3);
      default:    return cycle_frac(per, 1, 6);
    endcase
  endfunction
endpackage

// File: rtl/ilv3_timebase.sv
module ilv3_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_act,
  output logic [CW-1:0] count,
  output logic          wrap,
  output logic          zero_evt
);
  assign wrap = (count >= per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      zero_evt <= 1'b0;
    end else begin
      count    <= wrap ? '0 : count + 1'b1;
      zero_evt <= wrap;
    end
  end
endmodule

// File: rtl/ilv3_shadow.sv
module ilv3_shadow
  import ilv3_pkg::*;
#(
  parameter int CW      = 16,
  parameter int RST_PER = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              arm_load,
  input  logic              wrap,
  output logic [CW-1:0]     act [NSLOT],
  output logic              armed,
  output logic              load_evt
);
  logic [CW-1:0] shd [NSLOT];
  logic          addr_ok;

  assign addr_ok  = wr_en && (wr_addr < ADDR_W'(NSLOT));
  assign load_evt = wrap && armed;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[i] <= CW'(reset_slot(RST_PER, i));
        act[i] <= CW'(reset_slot(RST_PER, i));
      end else begin
        if (addr_ok && (wr_addr == ADDR_W'(i))) shd[i] <= wr_data;
        if (load_evt) act[i] <= shd[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (arm_load) armed <= 1'b1;
    else if (addr_ok)  armed <= 1'b0;
    else if (load_evt) armed <= 1'b0;
  end
endmodule

// File: rtl/ilv3_phase.sv
module ilv3_phase #(
  parameter int CW     = 16,
  parameter bit TOGGLE = 1'b1,
  parameter bit INIT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_x,
  input  logic [CW-1:0] cmp_y,
  output logic          q
);
  logic hit_x, hit_y;
  assign hit_x = (count == cmp_x);
  assign hit_y = (count == cmp_y);

  if (TOGGLE) begin : g_tog
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q <= INIT;
      else if (hit_x || hit_y) q <= ~q;
    end
  end else begin : g_setclr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= INIT;
      else if (hit_x) q <= 1'b1;
      else if (hit_y) q <= 1'b0;
    end
  end
endmodule

// File: rtl/ilv3_pwm.sv
module ilv3_pwm
  import ilv3_pkg::*;
#(
  parameter int CW      = 16,
  parameter int RST_PER = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              arm_load,
  output logic              phase_a,
  output logic              phase_b,
  output logic              phase_c,
  output logic              zero_evt,
  output logic [CW-1:0]     count
);
  logic [CW-1:0] act [NSLOT];
  logic          wrap_evt, load_evt, armed;
  logic [CW-1:0] act_per, act_a_clr, act_b_x, act_b_y, act_c_x, act_c_y;
  logic [CW-1:0] cx [NPHASE];
  logic [CW-1:0] cy [NPHASE];
  logic          pq [NPHASE];

  assign act_per   = act[SLOT_PER];
  assign act_a_clr = act[SLOT_A_CLR];
  assign act_b_x   = act[SLOT_B_X];
  assign act_b_y   = act[SLOT_B_Y];
  assign act_c_x   = act[SLOT_C_X];
  assign act_c_y   = act[SLOT_C_Y];

  ilv3_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .per_act(act_per),
    .count(count), .wrap(wrap_evt), .zero_evt(zero_evt)
  );

  ilv3_shadow #(.CW(CW), .RST_PER(RST_PER)) u_shd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arm_load(arm_load), .wrap(wrap_evt),
    .act(act), .armed(armed), .load_evt(load_evt)
  );

  assign cx[0] = '0;
  assign cy[0] = act_a_clr;
  assign cx[1] = act_b_x;
  assign cy[1] = act_b_y;
  assign cx[2] = act_c_x;
  assign cy[2] = act_c_y;

  for (genvar g = 0; g < NPHASE; g++) begin : g_ph
    ilv3_phase #(.CW(CW), .TOGGLE(g != 0), .INIT(g == 2)) u_ph (
      .clk(clk), .rst_n(rst_n), .count(count),
      .cmp_x(cx[g]), .cmp_y(cy[g]), .q(pq[g])
    );
  end

  assign phase_a = pq[0];
  assign phase_b = pq[1];
  assign phase_c = pq[2];
endmodule

// File: rtl/ilv3_pwm_chk.sv
module ilv3_pwm_chk #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          arm_load,
  input logic [CW-1:0] count,
  input logic          zero_evt,
  input logic          phase_a,
  input logic          phase_b,
  input logic          phase_c,
  input logic [CW-1:0] act_per,
  input logic [CW-1:0] act_b_x,
  input logic [CW-1:0] act_b_y,
  input logic [CW-1:0] act_c_x,
  input logic [CW-1:0] act_c_y,
  input logic          wrap_evt,
  input logic          load_evt,
  input logic          armed
);
  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= act_per);
  p_zero_after_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (zero_evt && count == '0));
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> (count == $past(count) + 1'b1 && !zero_evt));
  p_a_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> phase_a);
  p_b_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != act_b_x && count != act_b_y) |=> $stable(phase_b));
  p_c_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count != act_c_x && count != act_c_y) |=> $stable(phase_c));
  p_per_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_per));
  p_load_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (armed && wrap_evt));
  p_arm_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !arm_load && !wr_en) |=> !armed);
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < AW'(6) && !arm_load) |=> !armed);
endmodule

bind ilv3_pwm ilv3_pwm_chk #(.CW(CW), .AW(ilv3_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .arm_load(arm_load), .count(count), .zero_evt(zero_evt),
  .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c),
  .act_per(act_per), .act_b_x(act_b_x), .act_b_y(act_b_y),
  .act_c_x(act_c_x), .act_c_y(act_c_y), .wrap_evt(wrap_evt),
  .load_evt(load_evt), .armed(armed)
);

// File: tb/tb_ilv3_pwm.sv
`timescale 1ns/1ps
module tb_ilv3_pwm;
  localparam int CW = 16;
  localparam int NV = 14;
  // {we, addr[2:0], data[15:0], arm, idle[7:0]}
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 3'd0, 16'd11, 1'b0, 8'd0},
    {1'b1, 3'd1, 16'd6,  1'b0, 8'd0},
    {1'b1, 3'd2, 16'd4,  1'b0, 8'd0},
    {1'b1, 3'd3, 16'd10, 1'b0, 8'd0},
    {1'b1, 3'd4, 16'd8,  1'b0, 8'd0},
    {1'b1, 3'd5, 16'd2,  1'b0, 8'd0},
    {1'b0, 3'd0, 16'd0,  1'b1, 8'd60},
    {1'b1, 3'd0, 16'd35, 1'b0, 8'd0},
    {1'b1, 3'd1, 16'd18, 1'b0, 8'd0},
    {1'b1, 3'd2, 16'd12, 1'b0, 8'd0},
    {1'b1, 3'd3, 16'd30, 1'b0, 8'd0},
    {1'b1, 3'd4, 16'd24, 1'b0, 8'd0},
    {1'b1, 3'd5, 16'd6,  1'b0, 8'd0},
    {1'b0, 3'd0, 16'd0,  1'b1, 8'd120}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, arm_load = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic phase_a, phase_b, phase_c, zero_evt;
  logic [CW-1:0] count;
  int n_chk = 0, n_bad = 0;
  int maxc = 0;

  always #4 clk = ~clk;

  ilv3_pwm #(.CW(CW), .RST_PER(23)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .arm_load(arm_load), .phase_a(phase_a),
    .phase_b(phase_b), .phase_c(phase_c), .zero_evt(zero_evt), .count(count)
  );

  // independent model of the requirements
  int  m_ctr, m_act[6], m_shd[6];
  bit  m_arm, m_pa, m_pb, m_pc, m_zero;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctr <= 0; m_zero <= 0; m_arm <= 0;
      m_pa <= 0; m_pb <= 0; m_pc <= 1;
      m_act <= '{23, 12, 8, 20, 16, 4};
      m_shd <= '{23, 12, 8, 20, 16, 4};
    end else begin
      bit w, ld;
      w  = (m_ctr == m_act[0]);
      ld = w && m_arm;
      m_ctr  <= w ? 0 : m_ctr + 1;
      m_zero <= w;
      if (ld) m_act <= m_shd;
      if (wr_en && wr_addr < 6) m_shd[wr_addr] <= int'(wr_data);
      if (arm_load) m_arm <= 1;
      else if (wr_en && wr_addr < 6) m_arm <= 0;
      else if (ld) m_arm <= 0;
      if (m_ctr == 0) m_pa <= 1;
      else if (m_ctr == m_act[1]) m_pa <= 0;
      if (m_ctr == m_act[2] || m_ctr == m_act[3]) m_pb <= ~m_pb;
      if (m_ctr == m_act[4] || m_ctr == m_act[5]) m_pc <= ~m_pc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(count) == m_ctr, "R1 count", int'(count), m_ctr);
    chk(zero_evt == m_zero, "R1 zero_evt", int'(zero_evt), int'(m_zero));
    chk(phase_a == m_pa, "R2 phase_a", int'(phase_a), int'(m_pa));
    chk(phase_b == m_pb, "R3 phase_b", int'(phase_b), int'(m_pb));
    chk(phase_c == m_pc, "R3 phase_c", int'(phase_c), int'(m_pc));
    if (int'(count) > maxc) maxc = int'(count);
  endtask

  task automatic step(input bit we, input int a, input int d, input bit arm);
    wr_en = we; wr_addr = 3'(a); wr_data = CW'(d); arm_load = arm;
    @(negedge clk);
    wr_en = 0; arm_load = 0;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(count == '0, "R8 count", int'(count), 0);
    chk(zero_evt == 0, "R8 zero_evt", int'(zero_evt), 0);
    chk(phase_a == 0, "R8 phase_a", int'(phase_a), 0);
    chk(phase_b == 0, "R8 phase_b", int'(phase_b), 0);
    chk(phase_c == 1, "R8 phase_c", int'(phase_c), 1);
    maxc = 0; idle(30);
    chk(maxc == 23, "R8 reset period", maxc, 23);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][28], int'(VEC[v][27:25]), int'(VEC[v][24:9]), VEC[v][8]);
      idle(int'(VEC[v][7:0]));
    end
    maxc = 0; idle(40);
    chk(maxc == 35, "R5 table load", maxc, 35);

    // R4: writes without arm
    step(1, 0, 11, 0); step(1, 1, 6, 0); step(1, 2, 4, 0);
    step(1, 3, 10, 0); step(1, 4, 8, 0); step(1, 5, 2, 0);
    maxc = 0; idle(80);
    chk(maxc == 35, "R4 no arm", maxc, 35);

    // R6: arm then write cancels it
    step(0, 0, 0, 1); step(1, 1, 6, 0);
    maxc = 0; idle(80);
    chk(maxc == 35, "R6 cancelled arm", maxc, 35);

    // R5: arm alone loads at next wrap
    step(0, 0, 0, 1); idle(50);
    maxc = 0; idle(30);
    chk(maxc == 11, "R5 armed load", maxc, 11);

    // R7: period and compares in different periods, one arm
    step(1, 0, 17, 0);
    maxc = 0; idle(15);
    chk(maxc == 11, "R7 before arm", maxc, 11);
    step(1, 1, 9, 0); step(1, 2, 6, 0); step(1, 3, 15, 0);
    step(1, 4, 12, 0); step(1, 5, 3, 0);
    step(0, 0, 0, 1); idle(14);
    maxc = 0; idle(36);
    chk(maxc == 17, "R7 joint load", maxc, 17);

    // R9: addresses 6 and 7 are ignored and do not cancel an arm
    step(0, 0, 0, 1); step(1, 6, 3, 0); step(1, 7, 3, 0);
    maxc = 0; idle(40);
    chk(maxc == 17, "R9 invalid slots", maxc, 17);

    summary();
  end
endmodule